// File: doc/BRIEF.md
# Line Fill Buffer Tracker

This block keeps track of a small pool of line fill buffers for an instruction prefetcher. Once the fetch stream is redirected to a new target, the block opens one buffer per cache line. It begins with the line that holds the target and moves on to each following line. Every buffer fetches its line as a run of bus-width beats. The run starts at the beat that holds the buffer's address and wraps around the end of the line. All of this happens over an in-order, pipelined memory bus that uses request/grant and response-valid signals.

A pairwise age matrix sets the order of the buffers. The oldest buffer that still needs beats drives the bus. Each response goes to the oldest buffer that still has requests outstanding. The output side presents one beat address at a time, taken from the oldest live buffer, with an error flag. The beats come out in stream order.

When the stream is redirected, every buffer in flight is marked stale. A stale buffer still absorbs its pending responses so that bus ordering is kept, but it never produces output. Tag and data storage are not part of this block, and neither is instruction alignment.

Top module: `fill_tracker`

## Requirements
- R1: After reset, mem_req_o and out_valid_o are low. While no redirect has been seen, fetch_en_i alone opens no buffer and raises no request.
- R2: After a redirect to target T, the first output beat is the beat that contains T. Output then steps through that line's beats in increasing order, wraps to beat 0 and stops at the beat just before the first one. Every beat address has its byte-in-beat bits at zero.
- R3: Each buffer opened after the first fetches the next line in sequence. Buffers are reused once drained, so the output stream continues across more lines than there are buffers.
- R4: Over busy buffers the age relation is irreflexive, antisymmetric and total, and a row marks only busy buffers. Requests come from the oldest buffer still issuing. Responses go to the oldest buffer with outstanding requests. A younger buffer's output count stays zero while an older one still has output.
- R5: Once mem_req_o is high and the cycle has neither mem_gnt_i nor mem_perr_i, mem_req_o stays high in the next cycle with the same mem_addr_o.
- R6: A response that arrives with mem_rerr_i marks that beat. The beat is output with out_err_o high, that line produces nothing further, and output resumes at beat 0 of the next line.
- R7: When mem_perr_i squashes a request, the squashed beat is output with out_err_o high. Its buffer issues no further requests, no response is expected for the squashed beat, and output resumes at beat 0 of the next line.
- R8: A redirect marks every current buffer stale, and out_ready_i is ignored in that cycle. No beat from a stale buffer is ever output. Stale buffers still take their outstanding responses.
- R9: While out_valid_o is high and out_ready_i is low (and there is no redirect), out_valid_o, out_addr_o and out_err_o hold in the next cycle.
- R10: No buffer counts more requested, received or output beats than a line holds, and no buffer has received more beats than it requested. The sum over busy buffers of requested minus received beats equals the number of granted, unanswered bus transactions.
- R11: With fetch_en_i low, a redirect opens no new buffer. Once the stale buffers have drained, mem_req_o and out_valid_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en_i | input | 1 | Allows a new buffer to be opened |
| redirect_i | input | 1 | Redirects the fetch stream; all current buffers become stale |
| redirect_beat_i | input | AW-OW (30) | Redirect target with the byte-in-beat bits dropped |
| mem_req_o | output | 1 | Bus request |
| mem_addr_o | output | AW (32) | Beat address of the request |
| mem_gnt_i | input | 1 | Bus grant |
| mem_perr_i | input | 1 | Request squashed by an access-permission error |
| mem_rvalid_i | input | 1 | In-order response valid |
| mem_rerr_i | input | 1 | Response carries an error |
| out_valid_o | output | 1 | A beat is ready for the consumer |
| out_addr_o | output | AW (32) | Address of the offered beat |
| out_err_o | output | 1 | The offered beat has an error |
| out_ready_i | input | 1 | Consumer takes the offered beat |

## Verification
On every cycle the bound checker tests the age-matrix laws, the bounds on the beat counters, and the match between requested-minus-received beats and the transactions outstanding on the bus. It also checks the request hold rule and the output hold rule under stall, and that younger output counters stay at zero. Only the bench scenarios can show that beat ordering is correct end to end: the wrap from the target beat, the line-to-line chaining with buffer reuse, recovery after response and permission errors, and the suppression of stale data across a redirect that happens while responses are still in flight.

// File: rtl/fill_pkg.sv
package fill_pkg;
  localparam int unsigned DEF_NBUF       = 4;
  localparam int unsigned DEF_AW         = 32;
  localparam int unsigned DEF_LINE_BYTES = 16;
  localparam int unsigned DEF_BEAT_BYTES = 4;
endpackage

// File: rtl/fill_pick.sv
// Selects the oldest candidate: a candidate with no older candidate in its age row.
module fill_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0][N-1:0] age_i,
  input  logic [N-1:0]        cand_i,
  output logic [N-1:0]        pick_o
);
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign pick_o[i] = cand_i[i] & ~|(age_i[i] & cand_i);
  end
endmodule

// File: rtl/fill_age.sv
// Pairwise age matrix: row i holds the buffers older than buffer i.
module fill_age #(
  parameter int unsigned N = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       alloc_i,
  input  logic [N-1:0]       free_i,
  input  logic [N-1:0]       busy_i,
  output logic [N-1:0][N-1:0] age_o
);
  logic [N-1:0][N-1:0] age_q;

  for (genvar i = 0; i < N; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)             age_q[i] <= '0;
      else if (alloc_i[i]) age_q[i] <= busy_i & ~free_i;
      else                 age_q[i] <= age_q[i] & ~free_i;
    end
  end

  assign age_o = age_q;
endmodule

// File: rtl/fill_slot.sv
// One line fill buffer: beat counters, wrap-around beat indices and per-beat error flags.
module fill_slot #(
  parameter int unsigned AW         = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned BEAT_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_i,
  input  logic [AW-1:$clog2(BEAT_BYTES)] alloc_beat_i,
  input  logic                          stale_i,
  input  logic                          grant_i,
  input  logic                          squash_i,
  input  logic                          wait_i,
  input  logic                          resp_i,
  input  logic                          resp_err_i,
  input  logic                          take_i,
  input  logic                          free_i,
  output logic                          busy_o,
  output logic                          stale_o,
  output logic                          want_o,
  output logic                          has_out_o,
  output logic                          avail_o,
  output logic                          drained_o,
  output logic [AW-1:0]                 req_addr_o,
  output logic [AW-1:0]                 out_addr_o,
  output logic                          out_err_o,
  output logic [$clog2(LINE_BYTES/BEAT_BYTES):0] ext_cnt_o,
  output logic [$clog2(LINE_BYTES/BEAT_BYTES):0] rvd_cnt_o,
  output logic [$clog2(LINE_BYTES/BEAT_BYTES):0] out_cnt_o
);
  localparam int unsigned BEATS = LINE_BYTES / BEAT_BYTES;
  localparam int unsigned BW    = $clog2(BEATS);
  localparam int unsigned LW    = $clog2(LINE_BYTES);
  localparam int unsigned OW    = $clog2(BEAT_BYTES);
  localparam int unsigned CW    = BW + 1;

  logic              busy_q, stale_q, hold_q, stop_q, done_q;
  logic [AW-1:LW]    line_q;
  logic [BW-1:0]     first_q;
  logic [CW-1:0]     ext_q, rvd_q, out_q;
  logic [BEATS-1:0]  err_q;
  logic [BW-1:0]     ext_beat, rvd_beat, out_beat;

  assign ext_beat = first_q + ext_q[BW-1:0];
  assign rvd_beat = first_q + rvd_q[BW-1:0];
  assign out_beat = first_q + out_q[BW-1:0];

  assign want_o    = busy_q & ~stop_q & (ext_q < CW'(BEATS)) & (~stale_q | hold_q);
  assign avail_o   = (rvd_q > out_q) | err_q[out_beat];
  assign has_out_o = busy_q & ~stale_q & ~done_q;
  assign drained_o = busy_q & ~want_o & (rvd_q == ext_q) & (stale_q | done_q);

  assign req_addr_o = {line_q, ext_beat, {OW{1'b0}}};
  assign out_addr_o = {line_q, out_beat, {OW{1'b0}}};
  assign out_err_o  = err_q[out_beat];
  assign busy_o     = busy_q;
  assign stale_o    = stale_q;
  assign ext_cnt_o  = ext_q;
  assign rvd_cnt_o  = rvd_q;
  assign out_cnt_o  = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; stale_q <= 1'b0; hold_q <= 1'b0; stop_q <= 1'b0; done_q <= 1'b0;
      line_q <= '0; first_q <= '0; ext_q <= '0; rvd_q <= '0; out_q <= '0; err_q <= '0;
    end else if (alloc_i) begin
      busy_q  <= 1'b1; stale_q <= 1'b0; hold_q <= 1'b0; stop_q <= 1'b0; done_q <= 1'b0;
      line_q  <= alloc_beat_i[AW-1:LW];
      first_q <= alloc_beat_i[LW-1:OW];
      ext_q   <= '0; rvd_q <= '0; out_q <= '0; err_q <= '0;
    end else begin
      if (free_i) busy_q <= 1'b0;
      if (stale_i && busy_q) stale_q <= 1'b1;
      if (wait_i) hold_q <= 1'b1;
      if (grant_i) begin
        ext_q  <= ext_q + 1'b1;
        hold_q <= 1'b0;
      end
      if (squash_i) begin
        err_q[ext_beat] <= 1'b1;
        stop_q          <= 1'b1;
        hold_q          <= 1'b0;
      end
      if (resp_i) begin
        rvd_q <= rvd_q + 1'b1;
        if (resp_err_i) err_q[rvd_beat] <= 1'b1;
      end
      if (take_i) begin
        out_q <= out_q + 1'b1;
        if (err_q[out_beat] || out_q == CW'(BEATS - 1)) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
  parameter int unsigned NBUF       = fill_pkg::DEF_NBUF,
  parameter int unsigned AW         = fill_pkg::DEF_AW,
  parameter int unsigned LINE_BYTES = fill_pkg::DEF_LINE_BYTES,
  parameter int unsigned BEAT_BYTES = fill_pkg::DEF_BEAT_BYTES
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           fetch_en_i,
  input  logic                           redirect_i,
  input  logic [AW-1:$clog2(BEAT_BYTES)] redirect_beat_i,
  output logic                           mem_req_o,
  output logic [AW-1:0]                  mem_addr_o,
  input  logic                           mem_gnt_i,
  input  logic                           mem_perr_i,
  input  logic                           mem_rvalid_i,
  input  logic                           mem_rerr_i,
  output logic                           out_valid_o,
  output logic [AW-1:0]                  out_addr_o,
  output logic                           out_err_o,
  input  logic                           out_ready_i
);
  localparam int unsigned BEATS = LINE_BYTES / BEAT_BYTES;
  localparam int unsigned BW    = $clog2(BEATS);
  localparam int unsigned LW    = $clog2(LINE_BYTES);
  localparam int unsigned OW    = $clog2(BEAT_BYTES);
  localparam int unsigned CW    = BW + 1;
  localparam logic [AW-LW-1:0] LINE_ONE = 1;

  logic [NBUF-1:0]            busy, stale, want, has_out, avail, drained;
  logic [NBUF-1:0][AW-1:0]    req_addr, beat_addr;
  logic [NBUF-1:0]            beat_err;
  logic [NBUF-1:0][CW-1:0]    ext_cnt, rvd_cnt, out_cnt;
  logic [NBUF-1:0][NBUF-1:0]  age;
  logic [NBUF-1:0]            req_pick, resp_pick, out_pick, resp_cand;
  logic [NBUF-1:0]            grant_v, squash_v, wait_v, resp_v, take_v, alloc_v, free_oh;
  logic [AW-1:OW]             pf_q;
  logic                       pf_valid_q, alloc_go;

  // Next line to open; set by a redirect, then stepped one line per opened buffer.
  always_ff @(posedge clk) begin
    if (rst) begin
      pf_q       <= '0;
      pf_valid_q <= 1'b0;
    end else if (redirect_i) begin
      pf_q       <= redirect_beat_i;
      pf_valid_q <= 1'b1;
    end else if (alloc_go) begin
      pf_q <= {pf_q[AW-1:LW] + LINE_ONE, {(LW-OW){1'b0}}};
    end
  end

  always_comb begin
    free_oh = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (!busy[i]) free_oh = NBUF'(1) << i;
    end
  end

  assign alloc_go = fetch_en_i & ~redirect_i & pf_valid_q & |free_oh;
  assign alloc_v  = free_oh & {NBUF{alloc_go}};

  for (genvar i = 0; i < NBUF; i++) begin : g_cand
    assign resp_cand[i] = busy[i] & (rvd_cnt[i] < ext_cnt[i]);
  end

  fill_age #(.N(NBUF)) age_i (
    .clk(clk), .rst(rst), .alloc_i(alloc_v), .free_i(drained), .busy_i(busy), .age_o(age)
  );

  fill_pick #(.N(NBUF)) pick_req_i  (.age_i(age), .cand_i(want),      .pick_o(req_pick));
  fill_pick #(.N(NBUF)) pick_resp_i (.age_i(age), .cand_i(resp_cand), .pick_o(resp_pick));
  fill_pick #(.N(NBUF)) pick_out_i  (.age_i(age), .cand_i(has_out),   .pick_o(out_pick));

  assign grant_v  = req_pick & {NBUF{mem_gnt_i & ~mem_perr_i}};
  assign squash_v = req_pick & {NBUF{mem_perr_i}};
  assign wait_v   = req_pick & {NBUF{~mem_gnt_i & ~mem_perr_i}};
  assign resp_v   = resp_pick & {NBUF{mem_rvalid_i}};
  assign take_v   = out_pick & avail & {NBUF{out_ready_i & ~redirect_i}};

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    fill_slot #(.AW(AW), .LINE_BYTES(LINE_BYTES), .BEAT_BYTES(BEAT_BYTES)) slot_i (
      .clk(clk), .rst(rst),
      .alloc_i(alloc_v[i]), .alloc_beat_i(pf_q), .stale_i(redirect_i),
      .grant_i(grant_v[i]), .squash_i(squash_v[i]), .wait_i(wait_v[i]),
      .resp_i(resp_v[i]), .resp_err_i(mem_rerr_i), .take_i(take_v[i]), .free_i(drained[i]),
      .busy_o(busy[i]), .stale_o(stale[i]), .want_o(want[i]), .has_out_o(has_out[i]),
      .avail_o(avail[i]), .drained_o(drained[i]),
      .req_addr_o(req_addr[i]), .out_addr_o(beat_addr[i]), .out_err_o(beat_err[i]),
      .ext_cnt_o(ext_cnt[i]), .rvd_cnt_o(rvd_cnt[i]), .out_cnt_o(out_cnt[i])
    );
  end

  always_comb begin
    mem_addr_o = '0;
    out_addr_o = '0;
    out_err_o  = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      mem_addr_o = mem_addr_o | (req_addr[i] & {AW{req_pick[i]}});
      out_addr_o = out_addr_o | (beat_addr[i] & {AW{out_pick[i]}});
      out_err_o  = out_err_o | (beat_err[i] & out_pick[i]);
    end
  end

  assign mem_req_o   = |req_pick;
  assign out_valid_o = |(out_pick & avail);
endmodule

// File: rtl/fill_tracker_chk.sv
module fill_tracker_chk #(
  parameter int unsigned N     = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = 3,
  parameter int unsigned BEATS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [N-1:0]       busy,
  input logic [N-1:0]       has_out,
  input logic [N-1:0][N-1:0] age,
  input logic [N-1:0][CW-1:0] ext_cnt,
  input logic [N-1:0][CW-1:0] rvd_cnt,
  input logic [N-1:0][CW-1:0] out_cnt,
  input logic               mem_req,
  input logic [AW-1:0]      mem_addr,
  input logic               mem_gnt,
  input logic               mem_perr,
  input logic               mem_rvalid,
  input logic               out_valid,
  input logic [AW-1:0]      out_addr,
  input logic               out_err,
  input logic               out_ready,
  input logic               redirect
);
  logic [15:0] outstanding_q, inflight_sum;

  always_ff @(posedge clk) begin
    if (rst) outstanding_q <= '0;
    else outstanding_q <= outstanding_q + 16'(mem_req & mem_gnt & ~mem_perr) - 16'(mem_rvalid);
  end

  always_comb begin
    inflight_sum = '0;
    for (int i = 0; i < N; i++) begin
      if (busy[i]) inflight_sum = inflight_sum + 16'(ext_cnt[i]) - 16'(rvd_cnt[i]);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    a_r4_irreflexive: assert property (@(posedge clk) disable iff (rst) !age[i][i]);
    a_r4_row_busy: assert property (@(posedge clk) disable iff (rst)
      busy[i] |-> (age[i] & ~busy) == '0);
    a_r4_younger_idle: assert property (@(posedge clk) disable iff (rst)
      (has_out[i] && (age[i] & has_out) != '0) |-> out_cnt[i] == '0);
    a_r10_bounds: assert property (@(posedge clk) disable iff (rst)
      ext_cnt[i] <= CW'(BEATS) && out_cnt[i] <= CW'(BEATS) && rvd_cnt[i] <= ext_cnt[i]);
    for (genvar j = 0; j < i; j++) begin : g_pair
      a_r4_antisym: assert property (@(posedge clk) disable iff (rst)
        !(age[i][j] && age[j][i]));
      a_r4_total: assert property (@(posedge clk) disable iff (rst)
        (busy[i] && busy[j]) |-> (age[i][j] || age[j][i]));
    end
  end

  a_r10_outstanding: assert property (@(posedge clk) disable iff (rst)
    inflight_sum == outstanding_q);
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt && !mem_perr) |=> (mem_req && $stable(mem_addr)));
  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !redirect) |=>
      (out_valid && $stable(out_addr) && $stable(out_err)));
endmodule

bind fill_tracker fill_tracker_chk #(.N(NBUF), .AW(AW), .CW(CW), .BEATS(BEATS)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .has_out(has_out), .age(age),
  .ext_cnt(ext_cnt), .rvd_cnt(rvd_cnt), .out_cnt(out_cnt),
  .mem_req(mem_req_o), .mem_addr(mem_addr_o), .mem_gnt(mem_gnt_i), .mem_perr(mem_perr_i),
  .mem_rvalid(mem_rvalid_i), .out_valid(out_valid_o), .out_addr(out_addr_o),
  .out_err(out_err_o), .out_ready(out_ready_i), .redirect(redirect_i)
);

// File: tb/fill_tracker_tb_top.sv
`timescale 1ns/1ps
module fill_tracker_tb_top;
  localparam int LINE = 16;
  localparam int BEAT = 4;
  localparam int NB   = LINE / BEAT;
  localparam int LAT  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_en_i = 1'b0, redirect_i = 1'b0;
  logic [31:2] redirect_beat_i = '0;
  logic        mem_req_o, mem_gnt_i = 1'b0, mem_perr_i = 1'b0;
  logic        mem_rvalid_i = 1'b0, mem_rerr_i = 1'b0;
  logic [31:0] mem_addr_o, out_addr_o;
  logic        out_valid_o, out_err_o, out_ready_i = 1'b0;

  always #2.5 clk = ~clk;

  fill_tracker dut_i (.*);

  typedef struct packed { logic [31:0] a; logic e; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] pend_a[$];
  int          pend_t[$];
  int          errors = 0, checks = 0, cyc = 0;
  bit          k_fetch = 1'b0;
  int          k_gnt_mode = 0, k_rdy_mode = 0;
  logic [31:0] rerr_addr = 32'hFFFF_FFF0, perr_addr = 32'hFFFF_FFF0;
  logic [31:0] watch_addr = 32'hFFFF_FFF0;
  bit          watch_seen = 1'b0;
  bit          prev_wait = 1'b0, prev_stall = 1'b0, prev_err = 1'b0;
  logic [31:0] prev_addr = '0, prev_oaddr = '0;
  string       cur_tag = "R2";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Scoreboard driver: expected output beats for a stream beginning at target t.
  task automatic expect_stream(input logic [31:0] t, input int nlines, input logic [31:0] bad);
    logic [31:0] line = t & ~32'(LINE - 1);
    int          off  = int'((t % LINE) / BEAT);
    for (int l = 0; l < nlines; l++) begin
      for (int k = 0; k < NB; k++) begin
        logic [31:0] b = line + 32'(((off + k) % NB) * BEAT);
        exp_q.push_back({b, b == bad});
        if (b == bad) break;
      end
      line = line + 32'(LINE);
      off  = 0;
    end
  endtask

  // One cycle: sample at the falling edge, then drive the next inputs.
  task automatic cycle(input bit redir, input logic [31:0] raddr);
    bit g, p, rdy;
    @(negedge clk);
    cyc++;
    if (prev_wait) check(mem_req_o && mem_addr_o == prev_addr, "R5", "held request", mem_addr_o, prev_addr);
    if (prev_stall) begin
      check(out_valid_o && out_addr_o == prev_oaddr && out_err_o == prev_err, "R9",
            "stalled output", out_addr_o, prev_oaddr);
    end
    g = (k_gnt_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    p = mem_req_o && mem_addr_o == perr_addr;
    mem_gnt_i  = g;
    mem_perr_i = p;
    prev_wait  = mem_req_o && !g && !p;
    prev_addr  = mem_addr_o;
    if (mem_req_o && g && !p) begin
      pend_a.push_back(mem_addr_o);
      pend_t.push_back(cyc);
      if (mem_addr_o == watch_addr) watch_seen = 1'b1;
    end
    mem_rvalid_i = 1'b0;
    mem_rerr_i   = 1'b0;
    if (pend_a.size() > 0 && cyc - pend_t[0] >= LAT && (k_gnt_mode == 0 || (cyc % 4) != 1)) begin
      mem_rvalid_i = 1'b1;
      mem_rerr_i   = (pend_a[0] == rerr_addr);
      void'(pend_a.pop_front());
      void'(pend_t.pop_front());
    end
    rdy = (k_rdy_mode == 0 || (cyc % 3) == 0) && exp_q.size() > 0 && !redir;
    if (rdy && out_valid_o) begin
      exp_t e = exp_q.pop_front();
      check(out_addr_o == e.a, cur_tag, "beat address", out_addr_o, e.a);
      check(out_err_o == e.e, cur_tag, "beat error flag", 32'(out_err_o), 32'(e.e));
    end
    prev_stall      = out_valid_o && !rdy && !redir;
    prev_oaddr      = out_addr_o;
    prev_err        = out_err_o;
    out_ready_i     = rdy;
    redirect_i      = redir;
    redirect_beat_i = raddr[31:2];
    fetch_en_i      = k_fetch;
    if (redir) exp_q.delete();
  endtask

  task automatic wait_drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      cycle(1'b0, '0);
      n++;
    end
    check(exp_q.size() == 0, tag, "expected beats left", 32'(exp_q.size()), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
    summary();
  end

  initial begin
    int reqs = 0;
    repeat (3) @(negedge clk);
    check(!mem_req_o, "R1", "request in reset", 32'(mem_req_o), 0);
    check(!out_valid_o, "R1", "valid in reset", 32'(out_valid_o), 0);
    rst = 1'b0;
    // R1: fetch enabled but no redirect yet.
    k_fetch = 1'b1;
    for (int i = 0; i < 12; i++) begin
      cycle(1'b0, '0);
      if (mem_req_o || out_valid_o) reqs++;
    end
    check(reqs == 0, "R1", "activity before redirect", 32'(reqs), 0);

    // R2 / R3: unaligned target, long stream reusing buffers.
    cur_tag = "R3";
    cycle(1'b1, 32'h0000_0106);
    expect_stream(32'h0000_0106, 6, 32'hFFFF_FFF0);
    wait_drain("R3");

    // R4 / R5 / R9: grant and response gaps with an intermittent consumer.
    cur_tag = "R4"; k_gnt_mode = 1; k_rdy_mode = 1;
    cycle(1'b1, 32'h0000_2000);
    expect_stream(32'h0000_2000, 5, 32'hFFFF_FFF0);
    wait_drain("R4");

    // R8: redirect while responses for the first target are still in flight.
    cur_tag = "R8"; k_rdy_mode = 0;
    cycle(1'b1, 32'h0000_3008);
    expect_stream(32'h0000_3008, 3, 32'hFFFF_FFF0);
    repeat (6) cycle(1'b0, '0);
    cycle(1'b1, 32'h0000_400A);
    expect_stream(32'h0000_400A, 4, 32'hFFFF_FFF0);
    wait_drain("R8");
    k_gnt_mode = 0;

    // R6: error carried on a response.
    cur_tag = "R6"; rerr_addr = 32'h0000_5014;
    cycle(1'b1, 32'h0000_5010);
    expect_stream(32'h0000_5010, 3, rerr_addr);
    wait_drain("R6");
    rerr_addr = 32'hFFFF_FFF0;

    // R7: permission squash on a request; the buffer must not request the beat after it.
    cur_tag = "R7"; perr_addr = 32'h0000_6028; watch_addr = 32'h0000_602C; watch_seen = 1'b0;
    cycle(1'b1, 32'h0000_6020);
    expect_stream(32'h0000_6020, 3, perr_addr);
    wait_drain("R7");
    check(!watch_seen, "R7", "request after squash", 32'(watch_seen), 0);
    perr_addr = 32'hFFFF_FFF0;

    // R11 / R10: no new buffers with fetch disabled; stale buffers drain fully.
    k_fetch = 1'b0;
    cycle(1'b1, 32'h0000_7000);
    repeat (30) cycle(1'b0, '0);
    reqs = 0;
    for (int i = 0; i < 20; i++) begin
      cycle(1'b0, '0);
      if (mem_req_o || out_valid_o) reqs++;
    end
    check(reqs == 0, "R11", "activity with fetch disabled", 32'(reqs), 0);
    check(pend_a.size() == 0, "R10", "unanswered transactions", 32'(pend_a.size()), 0);
    summary();
  end
endmodule